// File: doc/BRIEF.md
# Per-Node Shared Bus Arbiter

Several processors share one external bus. Every processor carries one copy of this arbiter, and all copies see the same set of request lines, one line per node. The node that owns the bus keeps it until it lowers its own request line while some other line is raised. That cycle is the transition cycle. In it the owner turns its drivers off, and every copy picks the lowest-numbered raised line as the next owner.

Each copy follows the owner through the transition cycles, so all copies agree on the owner without any central logic. A copy also turns a local access request into a request line. It holds the local requester in a stall until the access has run. It drives the active-low memory selects and the driver enable for its node's address, data and strobe pins.

Node ID 0 selects single-node operation. In that mode the node owns the bus permanently.

Top module: `mp_bus_arbiter`

## Requirements
- R1: `br_out` (active high) rises in the same cycle that `acc_req` is high while the node is idle. It stays high through the cycle in which `acc_done` is sampled high, and it is low in the next cycle.
- R2: A transition cycle is a cycle in which the owner's request line is low and at least one line of `br_in` is high. Ownership changes only at the end of such a cycle. An idle owner keeps the bus while no line is raised, and an owner that raises its own line causes no transition.
- R3: Bit k of `br_in` is the request line of node ID k+1. In a transition cycle the lowest raised bit wins, and that node owns the bus from the next cycle. Other requesters keep their lines raised and wait for a later transition cycle, so every request is granted once the nodes ahead of it finish.
- R4: The owner holds `drv_en` low during the transition cycle. The new owner raises `drv_en` in its first cycle of ownership.
- R5: The owner keeps `drv_en` high in every cycle of ownership that is not a transition cycle, even with no access to run. Across nodes sharing the lines, at most one `drv_en` is high at any time.
- R6: `ms_n` is all ones except while a transfer runs. During a transfer only bit `acc_bank` is low. `ms_n` is all ones in every cycle in which `drv_en` is low.
- R7: A transfer starts only after the owner has sampled `ack` high. A transfer begins in the cycle after the first cycle in which the node is owner and `ack` is high. While `ack` is low, the node waits with `ms_n` all ones.
- R8: For a core access (`acc_core`=1), `core_stall` is high from the request cycle through the cycle in which `acc_done` is sampled, and it is low in the next cycle.
- R9: For a non-core access (`acc_core`=0), `io_stall` is high from the request cycle until the transfer begins, and it is low in every transfer cycle.
- R10: With `node_id`=0 the node always owns the bus and always drives it, whatever `br_in` carries. Its transfer starts two cycles after its request, as long as `ack` is high.
- R11: After reset, node ID 1 owns the bus with its drivers on. All other nodes have their drivers off, and no request line or stall is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| node_id | input | 3 | Strapped node ID; 0 = single-node mode |
| acc_req | input | 1 | Local access request, sampled when idle |
| acc_core | input | 1 | 1 = access from the core, 0 = from the DMA/IO side |
| acc_bank | input | 2 | Memory bank to select for the access |
| acc_done | input | 1 | Memory side reports that the running transfer is complete |
| core_stall | output | 1 | Holds the core until its access completes |
| io_stall | output | 1 | Holds the DMA/IO side until its transfer begins |
| br_in | input | NODES | Request lines of all nodes, bit k = node ID k+1 |
| br_out | output | 1 | This node's request line |
| ack | input | 1 | Bus ready, high = ready |
| ms_n | output | 4 | Memory selects, active low |
| drv_en | output | 1 | Enable for this node's address, data and strobe drivers |
| bus_owner | output | 1 | This node currently owns the bus |

## Verification
The request line, both stalls in the request cycle, and the driver-off of a transition cycle are combinational, so they are due in the same cycle as the stimulus. A new owner shows one edge after the transition cycle. A transfer's selects appear one edge after the owner samples `ack` high. Request and core stall fall one edge after `acc_done` is sampled. Inputs change at the falling edge, and every check samples one time unit later, counting the cycles listed here. A four-node bench on shared lines counts any cycle with two drivers on, and a burst phase confirms that every request is granted.

// File: rtl/mpa_pkg.sv
package mpa_pkg;
    localparam int ID_W      = 3;
    localparam int MAX_LINES = 7;
    localparam int LINE_VEC  = MAX_LINES + 1;
    localparam int SEL_W     = 4;
    localparam int BANK_W    = $clog2(SEL_W);

    typedef logic [ID_W-1:0]   node_id_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2
    } acc_state_e;

    typedef struct packed {
        logic  core;
        bank_t bank;
    } acc_ctx_t;

    typedef struct packed {
        logic     btc;
        logic     owner;
        node_id_t winner;
    } arb_view_t;

    // ID of the lowest raised line, 0 when none is raised
    function automatic node_id_t lowest_line(input logic [LINE_VEC-1:0] lines);
        node_id_t r;
        r = '0;
        for (int i = MAX_LINES - 1; i >= 0; i--) begin
            if (lines[i]) r = node_id_t'(i + 1);
        end
        return r;
    endfunction

    function automatic sel_t sel_code(input bank_t bank);
        return ~(sel_t'(1) << bank);
    endfunction
endpackage

// File: rtl/mpa_bus_watch.sv
module mpa_bus_watch
    import mpa_pkg::*;
#(
    parameter int NODES = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  node_id_t         node_id,
    input  logic [NODES-1:0] br_in,
    output arb_view_t        view
);
    logic [LINE_VEC-1:0] lines_ext;
    node_id_t            cur_m;
    logic                master_line;
    logic                any_line;
    logic                solo;

    assign lines_ext   = LINE_VEC'(br_in);
    assign master_line = lines_ext[cur_m - node_id_t'(1)];
    assign any_line    = |lines_ext;
    assign solo        = (node_id == '0);

    assign view.btc    = !solo && !master_line && any_line;
    assign view.winner = lowest_line(lines_ext);
    assign view.owner  = solo || (cur_m == node_id);

    // every copy tracks the owner; it only moves in a transition cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_m <= node_id_t'(1);
        end else if (!master_line && any_line) begin
            cur_m <= view.winner;
        end
    end

    // R2: owner line raised or no line raised -> owner unchanged
    a_r2_hold_without_btc: assert property (@(posedge clk) disable iff (rst)
        (master_line || !any_line) |=> $stable(cur_m));

    // R11: node 1 owns the bus right after reset
    a_r11_first_owner: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cur_m == node_id_t'(1)));
endmodule

// File: rtl/mpa_access_fsm.sv
module mpa_access_fsm
    import mpa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_req,
    input  logic       acc_core,
    input  bank_t      acc_bank,
    input  logic       acc_done,
    input  logic       ack,
    input  logic       owner,
    output acc_state_e state,
    output acc_ctx_t   ctx,
    output logic       br_out,
    output logic       core_stall,
    output logic       io_stall
);
    acc_state_e nxt;
    logic       idle;

    assign idle = (state == ST_IDLE);

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (acc_req)        nxt = ST_WAIT;
            ST_WAIT: if (owner && ack)   nxt = ST_XFER;
            ST_XFER: if (acc_done)       nxt = ST_IDLE;
            default:                     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ctx   <= '0;
        end else begin
            state <= nxt;
            if (idle && acc_req) begin
                ctx.core <= acc_core;
                ctx.bank <= acc_bank;
            end
        end
    end

    assign br_out     = idle ? acc_req : 1'b1;
    assign core_stall = idle ? (acc_req && acc_core) : ctx.core;
    assign io_stall   = idle ? (acc_req && !acc_core)
                             : ((state == ST_WAIT) && !ctx.core);

    // R1: the request line stays up until completion is sampled
    a_r1_req_line_held: assert property (@(posedge clk) disable iff (rst)
        (br_out && !acc_done) |=> br_out);

    // R8: a core stall is not released before completion
    a_r8_core_held: assert property (@(posedge clk) disable iff (rst)
        (core_stall && !acc_done) |=> core_stall);
endmodule

// File: rtl/mpa_drive_ctl.sv
module mpa_drive_ctl
    import mpa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       solo,
    input  arb_view_t  view,
    input  acc_state_e state,
    input  bank_t      bank,
    output logic       drv_en,
    output sel_t       ms_n
);
    assign drv_en = solo || (view.owner && !view.btc);
    assign ms_n   = (state == ST_XFER) ? sel_code(bank) : '1;

    // R6: selects parked high whenever drivers are off
    a_r6_sel_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !drv_en |-> (ms_n == '1));

    // R6: never more than one select active
    a_r6_one_sel: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ms_n));
endmodule

// File: rtl/mp_bus_arbiter.sv
module mp_bus_arbiter
    import mpa_pkg::*;
#(
    parameter int NODES = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ID_W-1:0]     node_id,
    input  logic                acc_req,
    input  logic                acc_core,
    input  logic [BANK_W-1:0]   acc_bank,
    input  logic                acc_done,
    output logic                core_stall,
    output logic                io_stall,
    input  logic [NODES-1:0]    br_in,
    output logic                br_out,
    input  logic                ack,
    output logic [SEL_W-1:0]    ms_n,
    output logic                drv_en,
    output logic                bus_owner
);
    arb_view_t  view;
    acc_state_e state;
    acc_ctx_t   ctx;
    logic       solo;

    assign solo      = (node_id == '0);
    assign bus_owner = view.owner;

    mpa_bus_watch #(.NODES(NODES)) u_watch (
        .clk    (clk),
        .rst    (rst),
        .node_id(node_id),
        .br_in  (br_in),
        .view   (view)
    );

    mpa_access_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .acc_req   (acc_req),
        .acc_core  (acc_core),
        .acc_bank  (acc_bank),
        .acc_done  (acc_done),
        .ack       (ack),
        .owner     (view.owner),
        .state     (state),
        .ctx       (ctx),
        .br_out    (br_out),
        .core_stall(core_stall),
        .io_stall  (io_stall)
    );

    mpa_drive_ctl u_drive (
        .clk   (clk),
        .rst   (rst),
        .solo  (solo),
        .view  (view),
        .state (state),
        .bank  (ctx.bank),
        .drv_en(drv_en),
        .ms_n  (ms_n)
    );

    logic [NODES-1:0] own_bit;
    logic [NODES-1:0] lower_mask;
    assign own_bit    = NODES'(1) << (node_id - node_id_t'(1));
    assign lower_mask = own_bit - NODES'(1);

    // R3: a node gains the bus only if its line was up and no lower line was
    a_r3_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        (!solo && $rose(bus_owner)) |->
            ((($past(br_in) & own_bit) != '0) && (($past(br_in) & lower_mask) == '0)));

    // R4: drivers go off only in a cycle where this owner's line is down
    a_r4_off_on_drop: assert property (@(posedge clk) disable iff (rst)
        (!solo && $fell(drv_en)) |-> (!br_out && bus_owner));

    // R4: the new owner drives in its first cycle
    a_r4_new_owner_drives: assert property (@(posedge clk) disable iff (rst)
        (!solo && $rose(bus_owner)) |-> drv_en);

    // R5: an owner with no line raised anywhere keeps driving
    a_r5_idle_owner_drives: assert property (@(posedge clk) disable iff (rst)
        (bus_owner && (br_in == '0)) |-> drv_en);

    // R7: the first select cycle follows a cycle with ack high
    a_r7_ack_first: assert property (@(posedge clk) disable iff (rst)
        ((ms_n != '1) && ($past(ms_n) == '1)) |-> $past(ack));

    // R9: the IO side is released once its transfer runs
    a_r9_io_free_in_xfer: assert property (@(posedge clk) disable iff (rst)
        (ms_n != '1) |-> !io_stall);

    // R10: single-node mode always owns and drives
    a_r10_solo_drives: assert property (@(posedge clk) disable iff (rst)
        solo |-> (drv_en && bus_owner));
endmodule

// File: tb/mp_bus_arbiter_bench.sv
module mp_bus_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NODES      = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NODES-1:0] acc_req, acc_core, acc_done;
    logic [NODES-1:0] br, drv, owner, cstall, iostall;
    logic [1:0]       acc_bank [NODES];
    logic [3:0]       ms_n     [NODES];
    logic             ack;

    logic       s_req, s_core, s_done, s_br, s_drv, s_own, s_cst, s_iost;
    logic [1:0] s_bank;
    logic [3:0] s_ms;
    logic [NODES-1:0] s_lines;

    int  checks = 0;
    int  errors = 0;
    int  conflicts = 0;
    bit  run_done = 0;

    initial begin
        acc_req = '0; acc_core = '0; ack = 1'b1;
        for (int i = 0; i < NODES; i++) acc_bank[i] = '0;
        s_req = 1'b0; s_core = 1'b0; s_bank = '0; s_lines = '1;
    end

    for (genvar g = 0; g < NODES; g++) begin : g_node
        mp_bus_arbiter #(.NODES(NODES)) u_mp_bus_arbiter (
            .clk(clk), .rst(rst), .node_id(3'(g + 1)),
            .acc_req(acc_req[g]), .acc_core(acc_core[g]), .acc_bank(acc_bank[g]),
            .acc_done(acc_done[g]), .core_stall(cstall[g]), .io_stall(iostall[g]),
            .br_in(br), .br_out(br[g]), .ack(ack), .ms_n(ms_n[g]),
            .drv_en(drv[g]), .bus_owner(owner[g])
        );
        // memory side: one-cycle transfers
        always @(negedge clk) acc_done[g] <= (ms_n[g] != 4'hF);
    end

    mp_bus_arbiter #(.NODES(NODES)) u_mp_bus_arbiter_solo (
        .clk(clk), .rst(rst), .node_id(3'd0),
        .acc_req(s_req), .acc_core(s_core), .acc_bank(s_bank),
        .acc_done(s_done), .core_stall(s_cst), .io_stall(s_iost),
        .br_in(s_lines), .br_out(s_br), .ack(ack), .ms_n(s_ms),
        .drv_en(s_drv), .bus_owner(s_own)
    );
    always @(negedge clk) s_done <= (s_ms != 4'hF);

    always @(negedge clk) if (!rst && ($countones(drv) > 1)) conflicts++;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R11", "owner during reset", 32'(owner), 32'b0001);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R11", "owner after reset", 32'(owner), 32'b0001);
        chk("R11", "drivers after reset", 32'(drv), 32'b0001);
        chk("R11", "request lines idle", 32'(br), 32'h0);
        chk("R11", "stalls idle", 32'({cstall, iostall}), 32'h0);
        chk("R6", "selects idle", 32'(ms_n[0]), 32'hF);
    endtask

    task automatic t_handover();
        @(negedge clk);
        acc_req[2] = 1'b1; acc_core[2] = 1'b1; acc_bank[2] = 2'd2; #1;
        chk("R1", "line rises with request", 32'(br[2]), 32'h1);
        chk("R4", "owner off in transition", 32'(drv), 32'h0);
        chk("R8", "core stall in request cycle", 32'(cstall[2]), 32'h1);
        @(negedge clk); acc_req[2] = 1'b0; #1;
        chk("R3", "node 3 owns", 32'(owner), 32'b0100);
        chk("R4", "new owner drives", 32'(drv), 32'b0100);
        chk("R6", "no select before transfer", 32'(ms_n[2]), 32'hF);
        @(negedge clk); #1;
        chk("R6", "bank 2 select", 32'(ms_n[2]), 32'b1011);
        chk("R8", "core stall during transfer", 32'(cstall[2]), 32'h1);
        chk("R1", "line held during transfer", 32'(br[2]), 32'h1);
        @(negedge clk); #1;
        chk("R1", "line drops after done", 32'(br[2]), 32'h0);
        chk("R8", "core stall released", 32'(cstall[2]), 32'h0);
        chk("R6", "selects parked", 32'(ms_n[2]), 32'hF);
        chk("R5", "idle owner keeps driving", 32'(drv), 32'b0100);
    endtask

    task automatic t_idle_keep();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            chk("R2", "idle owner retained", 32'(owner), 32'b0100);
            chk("R5", "idle owner drives", 32'(drv), 32'b0100);
        end
    endtask

    task automatic t_priority();
        @(negedge clk);
        acc_req[1] = 1'b1; acc_core[1] = 1'b1; acc_bank[1] = 2'd0;
        acc_req[3] = 1'b1; acc_core[3] = 1'b0; acc_bank[3] = 2'd3; #1;
        chk("R4", "transition drivers off", 32'(drv), 32'h0);
        chk("R9", "io stall in request cycle", 32'(iostall[3]), 32'h1);
        @(negedge clk); acc_req[1] = 1'b0; acc_req[3] = 1'b0; #1;
        chk("R3", "lowest line wins", 32'(owner), 32'b0010);
        chk("R3", "loser keeps line", 32'(br[3]), 32'h1);
        chk("R9", "io stall while waiting", 32'(iostall[3]), 32'h1);
        @(negedge clk); #1;
        chk("R6", "bank 0 select", 32'(ms_n[1]), 32'b1110);
        @(negedge clk); #1;
        chk("R4", "owner off when line drops", 32'(drv), 32'h0);
        chk("R2", "owner held in transition cycle", 32'(owner), 32'b0010);
        @(negedge clk); #1;
        chk("R3", "waiting node wins later", 32'(owner), 32'b1000);
        chk("R4", "node 4 drives", 32'(drv), 32'b1000);
        chk("R9", "io stall until transfer", 32'(iostall[3]), 32'h1);
        @(negedge clk); #1;
        chk("R6", "bank 3 select", 32'(ms_n[3]), 32'b0111);
        chk("R9", "io stall free in transfer", 32'(iostall[3]), 32'h0);
        @(negedge clk); #1;
        chk("R1", "node 4 line drops", 32'(br[3]), 32'h0);
    endtask

    task automatic t_ack_gate();
        @(negedge clk);
        ack = 1'b0;
        acc_req[0] = 1'b1; acc_core[0] = 1'b1; acc_bank[0] = 2'd1; #1;
        chk("R4", "transition to node 1", 32'(drv), 32'h0);
        @(negedge clk); acc_req[0] = 1'b0; #1;
        chk("R3", "node 1 owns", 32'(owner), 32'b0001);
        chk("R7", "waits while ack low", 32'(ms_n[0]), 32'hF);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); #1;
            chk("R7", "still waiting for ack", 32'(ms_n[0]), 32'hF);
            chk("R8", "core stalled while waiting", 32'(cstall[0]), 32'h1);
        end
        ack = 1'b1;
        @(negedge clk); #1;
        chk("R7", "transfer after ack", 32'(ms_n[0]), 32'b1101);
        @(negedge clk); #1;
        chk("R8", "core stall released", 32'(cstall[0]), 32'h0);
    endtask

    task automatic t_owner_rerequest();
        @(negedge clk);
        acc_req[0] = 1'b1; acc_core[0] = 1'b0; acc_bank[0] = 2'd3; #1;
        chk("R2", "own request keeps drivers", 32'(drv), 32'b0001);
        @(negedge clk); acc_req[0] = 1'b0; #1;
        chk("R2", "owner unchanged", 32'(owner), 32'b0001);
        @(negedge clk); #1;
        chk("R6", "bank 3 select for owner", 32'(ms_n[0]), 32'b0111);
        @(negedge clk); #1;
    endtask

    task automatic t_solo();
        @(negedge clk); #1;
        chk("R10", "solo owns with all lines up", 32'({s_own, s_drv}), 32'b11);
        @(negedge clk); s_req = 1'b1; s_core = 1'b1; s_bank = 2'd0; #1;
        chk("R10", "solo request line", 32'(s_br), 32'h1);
        @(negedge clk); s_req = 1'b0; #1;
        @(negedge clk); #1;
        chk("R10", "solo transfer", 32'(s_ms), 32'b1110);
        @(negedge clk); #1;
        chk("R10", "solo still drives", 32'(s_drv), 32'h1);
    endtask

    task automatic t_burst();
        int rem [NODES];
        int grants [NODES];
        int total;
        for (int i = 0; i < NODES; i++) begin
            rem[i] = 3; grants[i] = 0;
            acc_core[i] = i[0]; acc_bank[i] = 2'(i);
        end
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            acc_req = '0; #1;
            total = 0;
            for (int i = 0; i < NODES; i++) begin
                if (ms_n[i] != 4'hF) grants[i]++;
                if (!br[i] && rem[i] > 0) begin
                    acc_req[i] = 1'b1; rem[i]--;
                end
                total += grants[i];
            end
            if (total == 3 * NODES) break;
        end
        @(negedge clk); acc_req = '0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < NODES; i++)
            chk("R3", $sformatf("node %0d granted every request", i + 1), 32'(grants[i]), 32'd3);
        chk("R5", "cycles with two drivers", 32'(conflicts), 32'd0);
    endtask

    initial begin
        t_reset();
        t_handover();
        t_idle_keep();
        t_priority();
        t_ack_gate();
        t_owner_rerequest();
        t_solo();
        t_burst();
        run_done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!run_done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule